// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register File

This block collects sixteen asynchronous interrupt lines, turns each into a pending flag according to a per-line trigger mode, and offers the most urgent enabled line to a processor. Each line owns a 4-bit priority field, a mask bit and a 2-bit trigger-mode field. A small word-addressed register bus programs them all and reads them back. The line is then qualified by its mask bit and a nonzero priority, and a combinational arbiter reports the winner's index and priority together with a request flag.

Masking has two write ports. One address sets mask bits and another clears them, so software never has to do a read-modify-write. A priority of zero is a second way to switch a line off, and it does not depend on the mask. Edge-triggered lines hold their pending flag until software clears it. Level-triggered lines show the synchronized input directly.

Top module: `irqc_top`

## Requirements
- R1: After reset every priority field is 2, every line is masked, every trigger field is 3 (high level), no line is pending, irqReq is 0, and irqId and irqPrio are 0.
- R2: A write to address 4 sets the mask bit of each line whose data bit is 1. A write to address 5 clears it. Data bits of 0 leave the mask unchanged. Reading address 4 or address 5 returns the mask in bits 15:0, with zeros above.
- R3: Line j has its mask bit at data bit 15−j. A masked line never raises a request.
- R4: Priority fields live at address 0 (lines 0–7) and address 1 (lines 8–15). Line 8r+k uses bits [31−4k : 28−4k] of address r. Reads return the stored fields.
- R5: A line whose priority field is 0 never raises a request, whatever its mask bit holds.
- R6: Trigger fields live at address 2 (lines 0–7) and address 3 (lines 8–15). Line 8r+k uses bits [15−2k : 14−2k]. The codes are 0 = falling edge, 1 = rising edge, 2 = low level, 3 = high level.
- R7: In an edge mode, a matching transition on the input sets the pending flag by the third clock edge after the input changes. The flag then stays set after the input returns. A transition in the opposite direction sets nothing.
- R8: A write to address 6 clears the edge-mode pending flag of each line whose data bit 15−j is 1. Zero bits leave the flag unchanged. In level modes the write has no effect.
- R9: In a level mode the pending flag equals the input (high level) or its inverse (low level), as seen after two synchronizing flops.
- R10: Reading address 6 returns the pending flags, line j at bit 15−j.
- R11: irqReq is 1 when at least one pending, unmasked line has a nonzero priority. irqId names the eligible line with the largest priority, and ties go to the lowest index. irqPrio gives that line's priority. Without a request both are 0.
- R12: Addresses 7 to 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 4 | Register word address |
| busWrEn | input | 1 | Write strobe for busWrData at busAddr |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqIn | input | 16 | Raw interrupt lines, asynchronous |
| irqReq | output | 1 | Request: an eligible line exists |
| irqId | output | 4 | Index of the winning line |
| irqPrio | output | 4 | Priority of the winning line |

## Verification
Level mode is tested by raising one line at a time, which shows that each line maps to its own index and mask bit, and by holding all lines high while one mask bit is set at a time. Arithmetic priority patterns with many different values test the ordering by magnitude. An all-equal pattern tests the rule that ties go to the lowest index, and patterns with zeros mixed in test the second disable path. Edge modes are tested with rising, falling, return-to-idle and partial-clear sequences, which distinguish a latched flag from a followed one. Mixed trigger modes under a series of computed input words check that each line decodes its own trigger field.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_SENSE,
    RD_MASK,
    RD_PEND
  } rdKind_e;

  typedef struct packed {
    logic             prioWr;
    logic             senseWr;
    logic             maskSet;
    logic             maskClr;
    logic             pendClr;
    logic [SEL_W-1:0] sel;
    rdKind_e          rdKind;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqc_ctrl.sv
`timescale 1ns/1ps
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int NUM_PRIO_REGS  = 2,
  parameter int NUM_SENSE_REGS = 2
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      st
);
  localparam int SENSE_BASE    = NUM_PRIO_REGS;
  localparam int MASK_SET_ADDR = SENSE_BASE + NUM_SENSE_REGS;
  localparam int MASK_CLR_ADDR = MASK_SET_ADDR + 1;
  localparam int PEND_ADDR     = MASK_SET_ADDR + 2;

  int addrInt;
  assign addrInt = int'(busAddr);

  always_comb begin
    st        = '0;
    st.rdKind = RD_NONE;
    if (addrInt < SENSE_BASE) begin
      st.rdKind = RD_PRIO;
      st.sel    = SEL_W'(addrInt);
      st.prioWr = busWrEn;
    end else if (addrInt < MASK_SET_ADDR) begin
      st.rdKind  = RD_SENSE;
      st.sel     = SEL_W'(addrInt - SENSE_BASE);
      st.senseWr = busWrEn;
    end else if (addrInt == MASK_SET_ADDR) begin
      st.rdKind  = RD_MASK;
      st.maskSet = busWrEn;
    end else if (addrInt == MASK_CLR_ADDR) begin
      st.rdKind  = RD_MASK;
      st.maskClr = busWrEn;
    end else if (addrInt == PEND_ADDR) begin
      st.rdKind  = RD_PEND;
      st.pendClr = busWrEn;
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
`timescale 1ns/1ps
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int PRIO_W      = 4,
  parameter int PRIO_REG_W  = 32,
  parameter int SENSE_REG_W = 16,
  parameter int MASK_REG_W  = 16,
  parameter int DATA_W      = 32,
  parameter int RESET_PRIO  = 2,
  parameter int RESET_SENSE = 3,
  parameter int IDX_W       = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        st,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0]  irqIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqReq,
  output logic [IDX_W-1:0]    irqId,
  output logic [PRIO_W-1:0]   irqPrio
);
  localparam int PRIO_PER_REG  = PRIO_REG_W / PRIO_W;
  localparam int SENSE_PER_REG = SENSE_REG_W / 2;

  logic [NUM_SRC-1:0] syncA, syncB, prevB;
  logic [NUM_SRC-1:0] edgeLatch, maskQ;
  logic [NUM_SRC-1:0] hitVec, levelVec, pending, eligible;
  logic [PRIO_W-1:0]  prioQ  [NUM_SRC];
  logic [1:0]         senseQ [NUM_SRC];

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // per-line trigger decode
  for (genvar j = 0; j < NUM_SRC; j++) begin : g_src
    assign levelVec[j] = senseQ[j][1];
    assign hitVec[j]   = senseQ[j][0] ? (syncB[j] & ~prevB[j])
                                      : (~syncB[j] & prevB[j]);
    assign pending[j]  = levelVec[j] ? (senseQ[j][0] ? syncB[j] : ~syncB[j])
                                     : edgeLatch[j];
    assign eligible[j] = pending[j] & ~maskQ[j] & (|prioQ[j]);
  end

  // configuration fields, packed from the top of each register
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NUM_SRC; j++) begin
        prioQ[j]  <= PRIO_W'(RESET_PRIO);
        senseQ[j] <= 2'(RESET_SENSE);
      end
    end else begin
      for (int j = 0; j < NUM_SRC; j++) begin
        if (st.prioWr && st.sel == SEL_W'(j / PRIO_PER_REG))
          prioQ[j] <= wrData[PRIO_REG_W - (j % PRIO_PER_REG + 1) * PRIO_W +: PRIO_W];
        if (st.senseWr && st.sel == SEL_W'(j / SENSE_PER_REG))
          senseQ[j] <= wrData[SENSE_REG_W - (j % SENSE_PER_REG + 1) * 2 +: 2];
      end
    end
  end

  // mask set/clear and edge pending latches
  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ     <= '1;
      edgeLatch <= '0;
    end else begin
      for (int j = 0; j < NUM_SRC; j++) begin
        if (st.maskSet && wrData[MASK_REG_W-1-j])
          maskQ[j] <= 1'b1;
        else if (st.maskClr && wrData[MASK_REG_W-1-j])
          maskQ[j] <= 1'b0;

        if (levelVec[j])
          edgeLatch[j] <= 1'b0;
        else if (hitVec[j])
          edgeLatch[j] <= 1'b1;
        else if (st.pendClr && wrData[NUM_SRC-1-j])
          edgeLatch[j] <= 1'b0;
      end
    end
  end

  // register readback
  always_comb begin
    rdData = '0;
    case (st.rdKind)
      RD_PRIO:
        for (int k = 0; k < PRIO_PER_REG; k++)
          rdData[PRIO_REG_W - (k + 1) * PRIO_W +: PRIO_W] =
            prioQ[int'(st.sel) * PRIO_PER_REG + k];
      RD_SENSE:
        for (int k = 0; k < SENSE_PER_REG; k++)
          rdData[SENSE_REG_W - (k + 1) * 2 +: 2] =
            senseQ[int'(st.sel) * SENSE_PER_REG + k];
      RD_MASK:
        for (int j = 0; j < NUM_SRC; j++)
          rdData[MASK_REG_W-1-j] = maskQ[j];
      RD_PEND:
        for (int j = 0; j < NUM_SRC; j++)
          rdData[NUM_SRC-1-j] = pending[j];
      default: rdData = '0;
    endcase
  end

  // arbiter: strict greater-than keeps the lowest index on ties
  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  bestId;
  always_comb begin
    bestPrio = '0;
    bestId   = '0;
    for (int j = 0; j < NUM_SRC; j++) begin
      if (eligible[j] && prioQ[j] > bestPrio) begin
        bestPrio = prioQ[j];
        bestId   = IDX_W'(j);
      end
    end
  end

  assign irqReq  = |eligible;
  assign irqId   = bestId;
  assign irqPrio = bestPrio;
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int PRIO_W      = 4,
  parameter int PRIO_REG_W  = 32,
  parameter int SENSE_REG_W = 16,
  parameter int MASK_REG_W  = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int RESET_PRIO  = 2,
  parameter int RESET_SENSE = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic [DATA_W-1:0]          busWrData,
  output logic [DATA_W-1:0]          busRdData,
  input  logic [NUM_SRC-1:0]         irqIn,
  output logic                       irqReq,
  output logic [$clog2(NUM_SRC)-1:0] irqId,
  output logic [PRIO_W-1:0]          irqPrio
);
  localparam int IDX_W          = $clog2(NUM_SRC);
  localparam int NUM_PRIO_REGS  = NUM_SRC / (PRIO_REG_W / PRIO_W);
  localparam int NUM_SENSE_REGS = NUM_SRC / (SENSE_REG_W / 2);
  localparam int MASK_SET_ADDR  = NUM_PRIO_REGS + NUM_SENSE_REGS;

  ctrlStrobes_t st;

  irqc_ctrl #(
    .ADDR_W        (ADDR_W),
    .NUM_PRIO_REGS (NUM_PRIO_REGS),
    .NUM_SENSE_REGS(NUM_SENSE_REGS)
  ) u_ctrl (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .st     (st)
  );

  irqc_datapath #(
    .NUM_SRC    (NUM_SRC),
    .PRIO_W     (PRIO_W),
    .PRIO_REG_W (PRIO_REG_W),
    .SENSE_REG_W(SENSE_REG_W),
    .MASK_REG_W (MASK_REG_W),
    .DATA_W     (DATA_W),
    .RESET_PRIO (RESET_PRIO),
    .RESET_SENSE(RESET_SENSE),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .st     (st),
    .wrData (busWrData),
    .irqIn  (irqIn),
    .rdData (busRdData),
    .irqReq (irqReq),
    .irqId  (irqId),
    .irqPrio(irqPrio)
  );
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker #(
  parameter int NUM_SRC       = 16,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int MASK_REG_W    = 16,
  parameter int IDX_W         = 4,
  parameter int PRIO_W        = 4,
  parameter int MASK_SET_ADDR = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [DATA_W-1:0]  busWrData,
  input logic [NUM_SRC-1:0] irqIn,
  input logic               irqReq,
  input logic [IDX_W-1:0]   irqId,
  input logic [PRIO_W-1:0]  irqPrio
);
  logic [2:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R1: no request in the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irqReq);

  // R5: a winning line never carries priority zero
  p_req_prio_r5: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> irqPrio != '0);

  // R11: idle outputs are zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !irqReq |-> (irqId == '0 && irqPrio == '0));

  // R2: setting every mask bit silences the request on the next cycle
  p_mask_all_r2: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && int'(busAddr) == MASK_SET_ADDR && busWrData[MASK_REG_W-1:0] == '1)
      |=> !irqReq);

  // R7: with inputs quiet long enough and no writes, the outputs hold
  p_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (sinceRst > 3'd4 && !busWrEn && $stable(irqIn) && $past($stable(irqIn))
      && $past($stable(irqIn), 2))
      |=> ($stable(irqReq) && $stable(irqId) && $stable(irqPrio)));
endmodule

bind irqc_top irqc_checker #(
  .NUM_SRC      (NUM_SRC),
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .MASK_REG_W   (MASK_REG_W),
  .IDX_W        (IDX_W),
  .PRIO_W       (PRIO_W),
  .MASK_SET_ADDR(MASK_SET_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .irqIn    (irqIn),
  .irqReq   (irqReq),
  .irqId    (irqId),
  .irqPrio  (irqPrio)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [3:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [15:0] irqIn;
  logic        irqReq;
  logic [3:0]  irqId;
  logic [3:0]  irqPrio;

  irqc_top u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn),
    .irqReq(irqReq), .irqId(irqId), .irqPrio(irqPrio)
  );

  int       vectors = 0;
  int       fails   = 0;
  bit       done    = 0;
  int       mPrio  [N];
  bit       mMask  [N];
  bit [1:0] mSense [N];
  bit       mPe    [N];
  logic [15:0] curIn;

  function automatic bit expPend(int j);
    if (mSense[j][1]) return mSense[j][0] ? curIn[j] : !curIn[j];
    return mPe[j];
  endfunction

  function automatic logic [31:0] expPrioReg(int r);
    logic [31:0] v = '0;
    for (int k = 0; k < 8; k++) v[32 - 4*(k+1) +: 4] = 4'(mPrio[8*r+k]);
    return v;
  endfunction

  function automatic logic [31:0] expSenseReg(int r);
    logic [31:0] v = '0;
    for (int k = 0; k < 8; k++) v[16 - 2*(k+1) +: 2] = mSense[8*r+k];
    return v;
  endfunction

  function automatic logic [31:0] expMaskReg();
    logic [31:0] v = '0;
    for (int j = 0; j < N; j++) v[15-j] = mMask[j];
    return v;
  endfunction

  function automatic logic [31:0] expPendReg();
    logic [31:0] v = '0;
    for (int j = 0; j < N; j++) v[15-j] = expPend(j);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    busAddr   = 4'(a);
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
    if (a < 2) begin
      for (int k = 0; k < 8; k++) mPrio[8*a+k] = int'(d[32 - 4*(k+1) +: 4]);
    end else if (a < 4) begin
      for (int k = 0; k < 8; k++) begin
        mSense[8*(a-2)+k] = d[16 - 2*(k+1) +: 2];
        if (mSense[8*(a-2)+k][1]) mPe[8*(a-2)+k] = 0;
      end
    end else if (a == 4) begin
      for (int j = 0; j < N; j++) if (d[15-j]) mMask[j] = 1;
    end else if (a == 5) begin
      for (int j = 0; j < N; j++) if (d[15-j]) mMask[j] = 0;
    end else if (a == 6) begin
      for (int j = 0; j < N; j++) if (d[15-j] && !mSense[j][1]) mPe[j] = 0;
    end
  endtask

  task automatic setIn(logic [15:0] v);
    for (int j = 0; j < N; j++) begin
      if (mSense[j] == 2'd1 && !curIn[j] && v[j]) mPe[j] = 1;
      if (mSense[j] == 2'd0 && curIn[j] && !v[j]) mPe[j] = 1;
    end
    curIn = v;
    irqIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic rdChk(int a, logic [31:0] exp, string tag);
    busAddr = 4'(a);
    #1;
    chk($sformatf("%s addr%0d", tag, a), busRdData, exp);
  endtask

  task automatic checkAll(string tag);
    bit req = 0;
    int bestId = 0;
    int bestPr = 0;
    for (int j = 0; j < N; j++) begin
      if (expPend(j) && !mMask[j] && mPrio[j] != 0) begin
        req = 1;
        if (mPrio[j] > bestPr) begin
          bestPr = mPrio[j];
          bestId = j;
        end
      end
    end
    #1;
    chk({tag, "/R11 irqReq"},  {31'b0, irqReq},  {31'b0, req});
    chk({tag, "/R11 irqId"},   {28'b0, irqId},   32'(bestId));
    chk({tag, "/R11 irqPrio"}, {28'b0, irqPrio}, 32'(bestPr));
    rdChk(0, expPrioReg(0),  {tag, "/R4 prio"});
    rdChk(1, expPrioReg(1),  {tag, "/R4 prio"});
    rdChk(2, expSenseReg(0), {tag, "/R6 sense"});
    rdChk(3, expSenseReg(1), {tag, "/R6 sense"});
    rdChk(4, expMaskReg(),   {tag, "/R2 mask"});
    rdChk(5, expMaskReg(),   {tag, "/R3 mask"});
    rdChk(6, expPendReg(),   {tag, "/R10 pend"});
  endtask

  function automatic int prioPattern(int p, int j);
    if (p < 6)  return (j * (2*p + 3) + 5*p) % 16;
    if (p == 6) return 7;
    if (p < 11) return ((j + p) % 4 == 0) ? 0 : (j * 5 + p) % 16;
    return 0;
  endfunction

  task automatic pushPrio();
    wr(0, expPrioReg(0));
    wr(1, expPrioReg(1));
  endtask

  task automatic pushSense();
    logic [31:0] s0, s1;
    s0 = expSenseReg(0);
    s1 = expSenseReg(1);
    wr(2, s0);
    wr(3, s1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; busAddr = '0; busWrEn = 1'b0; busWrData = '0; irqIn = '0;
    curIn = '0;
    for (int j = 0; j < N; j++) begin
      mPrio[j] = 2; mMask[j] = 1; mSense[j] = 2'd3; mPe[j] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    checkAll("R1");

    // R2: set/clear masking, zero bits ignored
    wr(5, 32'h00F0); checkAll("R2 clr");
    wr(4, 32'h0030); checkAll("R2 set");
    wr(4, 32'h0000); checkAll("R2 zero");
    wr(5, 32'h0000); checkAll("R2 zero");
    wr(5, 32'hFFFF); checkAll("R2 clr all");

    // R9: one high-level line at a time
    for (int j = 0; j < N; j++) begin
      setIn(16'(1) << j);
      checkAll($sformatf("R9 line%0d", j));
    end

    // R3: all lines high, one mask bit at a time
    setIn(16'hFFFF);
    for (int j = 0; j < N; j++) begin
      wr(4, 32'h8000 >> j);
      checkAll($sformatf("R3 mask%0d", j));
      wr(5, 32'hFFFF);
    end

    // R4 / R5: priority patterns
    for (int p = 0; p < 12; p++) begin
      for (int j = 0; j < N; j++) mPrio[j] = prioPattern(p, j);
      pushPrio();
      checkAll(p < 7 ? "R4 pattern" : "R5 pattern");
    end
    // R5: zero priority beats an unmasked pending line, with some masks set
    wr(4, 32'h0F0F);
    checkAll("R5 masked");
    wr(5, 32'hFFFF);

    for (int j = 0; j < N; j++) mPrio[j] = 1 + j % 15;
    pushPrio();
    checkAll("R4 restore");

    // R7: rising edge latch and hold
    for (int j = 0; j < N; j++) mSense[j] = 2'd1;
    pushSense();
    setIn(16'h0000); checkAll("R7 fall ignored");
    setIn(16'hAAAA); checkAll("R7 rise");
    setIn(16'h0000); checkAll("R7 hold");
    // R8: partial clear, zero clear
    wr(6, 32'hF000); checkAll("R8 partial");
    wr(6, 32'h0000); checkAll("R8 zero");
    // R7: falling edge mode
    for (int j = 0; j < N; j++) mSense[j] = 2'd0;
    pushSense();
    setIn(16'hFFFF); checkAll("R7 rise ignored");
    setIn(16'h0F0F); checkAll("R7 fall");
    wr(6, 32'hFFFF); checkAll("R8 all");

    // R6: mixed trigger modes over computed input words
    for (int j = 0; j < N; j++) mSense[j] = 2'(j % 4);
    pushSense();
    for (int i = 0; i < 12; i++) begin
      setIn(16'(i * 16'h3A5B + 16'h1234));
      checkAll($sformatf("R6 mixed%0d", i));
    end
    wr(6, 32'hFFFF); checkAll("R8 mixed");

    // R9: low-level mode
    for (int j = 0; j < N; j++) mSense[j] = 2'd2;
    pushSense();
    for (int i = 0; i < 6; i++) begin
      setIn(16'(i * 16'h2D1F));
      checkAll($sformatf("R9 low%0d", i));
    end
    wr(6, 32'hFFFF); checkAll("R8 level");

    // R12: unmapped addresses
    for (int a = 7; a < 16; a++) wr(a, 32'hFFFF_FFFF);
    checkAll("R12 writes");
    for (int a = 7; a < 16; a++) rdChk(a, 32'h0, "R12 read");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule